// File: doc/BRIEF.md
# Address-Load Hazard Window Detector

This block watches a stream of decoded shader instructions and flags short instruction sequences that can stall the shader core for good. These sequences all involve an instruction that loads the address register, called "address load" below. The instruction stream arrives over a valid/ready handshake. Each instruction carries an opcode class, a destination register (type and index), two source registers (type and index each), a flag marking a write to an output register, and a flag marking that the instruction indexes through the address register.

The two most recently accepted instructions are kept in a small window. Each new instruction is compared against a fixed set of adjacent-instruction patterns. For every pattern that completes, the block emits a one-cycle warning pulse that carries a 32-bit hazard code. When one instruction completes several patterns, the codes come out one per cycle in ascending order. During that drain the handshake is held off. The block does not model stall timing, and it does not pair structured control flow.

Top module: `hzd_detect`

## Requirements
- R1: After reset `in_ready` is 1 and `warn_valid` is 0, and the window is empty. A pattern fires only when all of its instructions were accepted since the last reset, so an end arriving as the first instruction, or just after a reset, raises nothing.
- R2: An address load (opcode 2) directly followed by an end (opcode 3) raises code 0x400a0003.
- R3: An address load, then an instruction with the output-write flag set and the address-use flag clear, then an end, raises code 0x400a0004 on the end.
- R4: If the middle instruction of the R3 sequence has its address-use flag set, no code is raised.
- R5: An address load whose source 0 has type temporary (type 1), directly followed by a branch, raises code 0x400a0005. A stall is not checked. An address load whose source 0 has any other type raises nothing on a following branch.
- R6: The branch class is exactly opcodes 8 to 15, which are the eight kinds: jump on boolean, jump on condition, call, call on boolean, call on condition, if on boolean, if on condition and break on condition. Opcodes 4 to 7 are not branches.
- R7: An address load whose source 0 has type input (type 2), followed by two instructions that each read the same input register on either source, raises code 0x400a0006 on the second of those two.
- R8: Two registers are the same only when both type and index match, and type 0 (none) never matches. A different index or a different type breaks R7.
- R9: Each warning is a one-cycle pulse on `warn_valid`. It appears in the cycle after the accepting clock edge of the instruction that completed the pattern.
- R10: When several patterns complete on one instruction, the lowest code is reported first and the rest follow on later cycles in ascending order. `in_ready` is low exactly while codes are still queued.
- R11: Patterns are strictly adjacent. Any instruction inserted between the parts of a pattern, for example a nop (opcode 0), prevents the match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction present |
| in_ready | output | 1 | Block can accept an instruction |
| in_op | input | 4 | Opcode class |
| in_dst_type | input | 2 | Destination register type |
| in_dst_idx | input | 5 | Destination register index |
| in_src0_type | input | 2 | Source 0 register type (0 none, 1 temporary, 2 input, 3 constant) |
| in_src0_idx | input | 5 | Source 0 register index |
| in_src1_type | input | 2 | Source 1 register type |
| in_src1_idx | input | 5 | Source 1 register index |
| in_out_wr | input | 1 | Instruction writes an output register |
| in_addr_use | input | 1 | Instruction indexes through the address register |
| warn_valid | output | 1 | Warning pulse |
| warn_code | output | 32 | Hazard code of the current warning |

## Verification
The hardest state to reach is a queued second warning, because it needs one instruction to complete two patterns at once. The bench gets there in two ways. In the first, two address loads in a row, the second sourcing a temporary and also reading the first one's input register, are followed by a branch that reads that same input. In the second, a similar pair is followed by an end. The bench then follows `in_ready` through the drain cycle and checks that the codes arrive in order. Resetting between the two halves of a pattern is the other awkward case, and the bench covers it directly.

// File: rtl/hzd_pkg.sv
package hzd_pkg;

  localparam int REG_IDX_W = 5;
  localparam int OPC_W     = 4;
  localparam int RTYPE_W   = 2;
  localparam int WIN_DEPTH = 2;
  localparam int NUM_HAZ   = 4;
  localparam int HAZ_IW    = $clog2(NUM_HAZ);
  localparam int CODE_W    = 32;
  localparam logic [CODE_W-1:0] CODE_BASE = 32'h400a0003;

  // hazard slots, index order is report priority
  localparam int HZ_AMOV_END     = 0;
  localparam int HZ_AMOV_OUT_END = 1;
  localparam int HZ_AMOV_BRANCH  = 2;
  localparam int HZ_INPUT_PAIR   = 3;

  typedef enum logic [OPC_W-1:0] {
    OPC_NOP   = 4'd0,
    OPC_ALU   = 4'd1,
    OPC_AMOV  = 4'd2,
    OPC_END   = 4'd3,
    OPC_JMP_B = 4'd8,
    OPC_JMP_C = 4'd9,
    OPC_CALL  = 4'd10,
    OPC_CALLB = 4'd11,
    OPC_CALLC = 4'd12,
    OPC_IF_B  = 4'd13,
    OPC_IF_C  = 4'd14,
    OPC_BRK_C = 4'd15
  } opc_e;

  typedef enum logic [RTYPE_W-1:0] {
    RT_NONE  = 2'd0,
    RT_TEMP  = 2'd1,
    RT_INPUT = 2'd2,
    RT_CONST = 2'd3
  } rtype_e;

  typedef struct packed {
    logic [OPC_W-1:0]     opc;
    logic [RTYPE_W-1:0]   dst_t;
    logic [REG_IDX_W-1:0] dst_i;
    logic [RTYPE_W-1:0]   s0_t;
    logic [REG_IDX_W-1:0] s0_i;
    logic [RTYPE_W-1:0]   s1_t;
    logic [REG_IDX_W-1:0] s1_i;
    logic                 out_wr;
    logic                 addr_use;
  } instr_t;

  function automatic logic [CODE_W-1:0] haz_code(input logic [HAZ_IW-1:0] k);
    return CODE_BASE + CODE_W'(k);
  endfunction

  // branch kinds occupy the upper half of the opcode space
  function automatic logic is_branch(input logic [OPC_W-1:0] opc);
    return opc[OPC_W-1];
  endfunction

endpackage

// File: rtl/hzd_window.sv
module hzd_window
  import hzd_pkg::*;
#(
  parameter int DEPTH = WIN_DEPTH
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 shift,
  input  instr_t               in_ins,
  output instr_t [DEPTH-1:0]   slot,
  output logic   [DEPTH-1:0]   slot_vld
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot     <= '0;
      slot_vld <= '0;
    end else if (shift) begin
      for (int i = DEPTH - 1; i > 0; i--) begin
        slot[i]     <= slot[i-1];
        slot_vld[i] <= slot_vld[i-1];
      end
      slot[0]     <= in_ins;
      slot_vld[0] <= 1'b1;
    end
  end

  // R1: slots fill strictly in order after reset
  generate
    for (genvar g = 1; g < DEPTH; g++) begin : g_fill_chk
      a_r1_fill_order: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_vld[g-1] |-> !slot_vld[g]);
    end
  endgenerate

  a_r1_head_fill: assert property (@(posedge clk) disable iff (!rst_n)
    shift |=> slot_vld[0]);

endmodule

// File: rtl/hzd_match.sv
module hzd_match
  import hzd_pkg::*;
(
  input  instr_t               cur,
  input  instr_t               p1,
  input  instr_t               p2,
  input  logic                 p1_vld,
  input  logic                 p2_vld,
  output logic [NUM_HAZ-1:0]   hit
);

  function automatic logic same_reg(input logic [RTYPE_W-1:0] ta,
                                    input logic [REG_IDX_W-1:0] ia,
                                    input logic [RTYPE_W-1:0] tb,
                                    input logic [REG_IDX_W-1:0] ib);
    return (ta != RT_NONE) && (ta == tb) && (ia == ib);
  endfunction

  function automatic logic reads_reg(input instr_t ins,
                                     input logic [RTYPE_W-1:0] t,
                                     input logic [REG_IDX_W-1:0] i);
    return same_reg(ins.s0_t, ins.s0_i, t, i) || same_reg(ins.s1_t, ins.s1_i, t, i);
  endfunction

  logic p1_amov, p2_amov, cur_end, cur_branch;
  logic pat_amov_end, pat_amov_out_end, pat_amov_branch, pat_input_pair;
  logic unused_fields;

  assign p1_amov    = p1_vld && (p1.opc == OPC_AMOV);
  assign p2_amov    = p2_vld && (p2.opc == OPC_AMOV);
  assign cur_end    = (cur.opc == OPC_END);
  assign cur_branch = is_branch(cur.opc);

  assign pat_amov_end     = p1_amov && cur_end;
  assign pat_amov_out_end = p2_amov && p1_vld && p1.out_wr && !p1.addr_use && cur_end;
  assign pat_amov_branch  = p1_amov && (p1.s0_t == RT_TEMP) && cur_branch;
  assign pat_input_pair   = p2_amov && p1_vld && (p2.s0_t == RT_INPUT)
                          && reads_reg(p1, p2.s0_t, p2.s0_i)
                          && reads_reg(cur, p2.s0_t, p2.s0_i);

  always_comb begin
    hit                  = '0;
    hit[HZ_AMOV_END]     = pat_amov_end;
    hit[HZ_AMOV_OUT_END] = pat_amov_out_end;
    hit[HZ_AMOV_BRANCH]  = pat_amov_branch;
    hit[HZ_INPUT_PAIR]   = pat_input_pair;
  end

  assign unused_fields = ^{cur, p1, p2};

endmodule

// File: rtl/hzd_report.sv
module hzd_report
  import hzd_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 accept,
  input  logic [NUM_HAZ-1:0]   hit,
  output logic                 busy,
  output logic                 warn_valid,
  output logic [CODE_W-1:0]    warn_code
);

  function automatic logic [HAZ_IW-1:0] lowest(input logic [NUM_HAZ-1:0] v);
    logic [HAZ_IW-1:0] r = '0;
    for (int k = NUM_HAZ - 1; k >= 0; k--)
      if (v[k]) r = HAZ_IW'(k);
    return r;
  endfunction

  logic [NUM_HAZ-1:0] pending_q;
  logic [NUM_HAZ-1:0] src;

  assign src  = pending_q | (accept ? hit : '0);
  assign busy = (pending_q != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending_q  <= '0;
      warn_valid <= 1'b0;
      warn_code  <= '0;
    end else if (src != '0) begin
      warn_valid <= 1'b1;
      warn_code  <= haz_code(lowest(src));
      pending_q  <= src & (src - 1'b1);
    end else begin
      warn_valid <= 1'b0;
    end
  end

  a_r10_drain: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> warn_valid);

  a_r10_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    (warn_valid && $past(busy)) |-> (warn_code > $past(warn_code)));

  a_r9_caused: assert property (@(posedge clk) disable iff (!rst_n)
    warn_valid |-> ($past(accept) || $past(busy)));

endmodule

// File: rtl/hzd_detect.sv
module hzd_detect
  import hzd_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [OPC_W-1:0]       in_op,
  input  logic [RTYPE_W-1:0]     in_dst_type,
  input  logic [REG_IDX_W-1:0]   in_dst_idx,
  input  logic [RTYPE_W-1:0]     in_src0_type,
  input  logic [REG_IDX_W-1:0]   in_src0_idx,
  input  logic [RTYPE_W-1:0]     in_src1_type,
  input  logic [REG_IDX_W-1:0]   in_src1_idx,
  input  logic                   in_out_wr,
  input  logic                   in_addr_use,
  output logic                   warn_valid,
  output logic [CODE_W-1:0]      warn_code
);

  instr_t                  cur;
  instr_t [WIN_DEPTH-1:0]  slot;
  logic   [WIN_DEPTH-1:0]  slot_vld;
  logic   [NUM_HAZ-1:0]    hit;
  logic                    accept;
  logic                    busy;

  assign cur = '{opc: in_op, dst_t: in_dst_type, dst_i: in_dst_idx,
                 s0_t: in_src0_type, s0_i: in_src0_idx,
                 s1_t: in_src1_type, s1_i: in_src1_idx,
                 out_wr: in_out_wr, addr_use: in_addr_use};

  assign in_ready = !busy;
  assign accept   = in_valid && in_ready;

  hzd_window #(.DEPTH(WIN_DEPTH)) u_window (
    .clk(clk), .rst_n(rst_n), .shift(accept), .in_ins(cur),
    .slot(slot), .slot_vld(slot_vld)
  );

  hzd_match u_match (
    .cur(cur), .p1(slot[0]), .p2(slot[1]),
    .p1_vld(slot_vld[0]), .p2_vld(slot_vld[1]), .hit(hit)
  );

  hzd_report u_report (
    .clk(clk), .rst_n(rst_n), .accept(accept), .hit(hit), .busy(busy),
    .warn_valid(warn_valid), .warn_code(warn_code)
  );

  // R10: the handshake only stalls while a queued code is being emitted
  a_r10_stall_has_warn: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> warn_valid);

  // R9: an accepted instruction with a match is reported in the next cycle
  a_r9_report_next: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (hit != '0)) |=> warn_valid);

endmodule

// File: tb/hzd_detect_bench.sv
module hzd_detect_bench;

  localparam logic [3:0] OP_NOP = 4'd0, OP_ALU = 4'd1, OP_AMOV = 4'd2, OP_END = 4'd3;
  localparam logic [3:0] OP_JMP_C = 4'd9, OP_CALL = 4'd10;
  localparam logic [1:0] T_NONE = 2'd0, T_TEMP = 2'd1, T_IN = 2'd2, T_CONST = 2'd3;
  localparam logic [31:0] W3 = 32'h400a0003, W4 = 32'h400a0004,
                          W5 = 32'h400a0005, W6 = 32'h400a0006;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [3:0] in_op = '0;
  logic [1:0] in_dst_type = T_TEMP, in_src0_type = '0, in_src1_type = '0;
  logic [4:0] in_dst_idx = 5'd7, in_src0_idx = '0, in_src1_idx = '0;
  logic in_out_wr = 1'b0, in_addr_use = 1'b0;
  logic warn_valid;
  logic [31:0] warn_code;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  hzd_detect u_hzd_detect (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_dst_type(in_dst_type), .in_dst_idx(in_dst_idx),
    .in_src0_type(in_src0_type), .in_src0_idx(in_src0_idx),
    .in_src1_type(in_src1_type), .in_src1_idx(in_src1_idx),
    .in_out_wr(in_out_wr), .in_addr_use(in_addr_use),
    .warn_valid(warn_valid), .warn_code(warn_code)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // send one instruction, collect every warning it produces
  task automatic issue(input logic [3:0] o, input logic [1:0] at, input logic [4:0] ai,
                       input logic [1:0] bt, input logic [4:0] bi, input logic w, input logic u,
                       input int n_exp, input logic [31:0] e0, input logic [31:0] e1,
                       input string req);
    logic [31:0] codes [4];
    int got = 0;
    bit stalled = 0;
    in_op = o; in_src0_type = at; in_src0_idx = ai;
    in_src1_type = bt; in_src1_idx = bi; in_out_wr = w; in_addr_use = u;
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    for (int k = 0; k < 8; k++) begin
      if (warn_valid) begin
        if (got < 4) codes[got] = warn_code;
        got++;
      end
      if (in_ready) break;
      stalled = 1;
      @(negedge clk);
    end
    chk(got == n_exp, req, 32'(got), 32'(n_exp));
    if (n_exp >= 1 && got >= 1) chk(codes[0] == e0, req, codes[0], e0);
    if (n_exp == 2 && got >= 2) begin
      chk(codes[1] == e1, req, codes[1], e1);
      chk(stalled == 1'b1, {req, " ready low during drain"}, 32'(stalled), 32'd1);
    end
  endtask

  task automatic flush();
    issue(OP_NOP, T_NONE, 0, T_NONE, 0, 0, 0, 0, 0, 0, "R11 flush");
    issue(OP_NOP, T_NONE, 0, T_NONE, 0, 0, 0, 0, 0, 0, "R11 flush");
  endtask

  task automatic t_reset();
    do_reset();
    chk(in_ready == 1'b1, "R1 ready after reset", 32'(in_ready), 32'd1);
    chk(warn_valid == 1'b0, "R1 no warning after reset", 32'(warn_valid), 32'd0);
    issue(OP_END, T_NONE, 0, T_NONE, 0, 0, 0, 0, 0, 0, "R1 end into empty window");
  endtask

  task automatic t_amov_end();
    issue(OP_AMOV, T_TEMP, 0, T_NONE, 0, 0, 0, 0, 0, 0, "R2 load alone");
    issue(OP_END, T_NONE, 0, T_NONE, 0, 0, 0, 1, W3, 0, "R2 load then end");
    @(negedge clk);
    chk(warn_valid == 1'b0, "R9 pulse lasts one cycle", 32'(warn_valid), 32'd0);
  endtask

  task automatic t_out_end();
    flush();
    issue(OP_AMOV, T_TEMP, 1, T_NONE, 0, 0, 0, 0, 0, 0, "R3 load");
    issue(OP_ALU, T_CONST, 2, T_NONE, 0, 1, 0, 0, 0, 0, "R3 output write");
    issue(OP_END, T_NONE, 0, T_NONE, 0, 0, 0, 1, W4, 0, "R3 load, write, end");
  endtask

  task automatic t_addr_use();
    flush();
    issue(OP_AMOV, T_TEMP, 1, T_NONE, 0, 0, 0, 0, 0, 0, "R4 load");
    issue(OP_ALU, T_CONST, 2, T_NONE, 0, 1, 1, 0, 0, 0, "R4 indexed output write");
    issue(OP_END, T_NONE, 0, T_NONE, 0, 0, 0, 0, 0, 0, "R4 end after indexed write");
  endtask

  task automatic t_branch();
    flush();
    for (int k = 8; k < 16; k++) begin
      issue(OP_AMOV, T_TEMP, 4, T_NONE, 0, 0, 0, 0, 0, 0, "R6 load before branch");
      issue(4'(k), T_NONE, 0, T_NONE, 0, 0, 0, 1, W5, 0, "R5 R6 temp load then branch");
    end
    issue(OP_AMOV, T_IN, 4, T_NONE, 0, 0, 0, 0, 0, 0, "R5 input load");
    issue(OP_CALL, T_NONE, 0, T_NONE, 0, 0, 0, 0, 0, 0, "R5 input load then branch");
    for (int k = 4; k < 8; k++) begin
      issue(OP_AMOV, T_TEMP, 4, T_NONE, 0, 0, 0, 0, 0, 0, "R6 load before non-branch");
      issue(4'(k), T_NONE, 0, T_NONE, 0, 0, 0, 0, 0, 0, "R6 opcode 4..7 not a branch");
    end
  endtask

  task automatic t_input_pair();
    flush();
    issue(OP_AMOV, T_IN, 3, T_NONE, 0, 0, 0, 0, 0, 0, "R7 input load");
    issue(OP_ALU, T_CONST, 0, T_IN, 3, 0, 0, 0, 0, 0, "R7 first reader");
    issue(OP_ALU, T_IN, 3, T_NONE, 0, 0, 0, 1, W6, 0, "R7 second reader");
  endtask

  task automatic t_same_reg();
    flush();
    issue(OP_AMOV, T_IN, 3, T_NONE, 0, 0, 0, 0, 0, 0, "R8 load");
    issue(OP_ALU, T_IN, 4, T_NONE, 0, 0, 0, 0, 0, 0, "R8 other index");
    issue(OP_ALU, T_IN, 3, T_NONE, 0, 0, 0, 0, 0, 0, "R8 index mismatch breaks rule");
    flush();
    issue(OP_AMOV, T_IN, 3, T_NONE, 0, 0, 0, 0, 0, 0, "R8 load");
    issue(OP_ALU, T_TEMP, 3, T_NONE, 0, 0, 0, 0, 0, 0, "R8 other type");
    issue(OP_ALU, T_IN, 3, T_NONE, 0, 0, 0, 0, 0, 0, "R8 type mismatch breaks rule");
  endtask

  task automatic t_multi();
    flush();
    issue(OP_AMOV, T_IN, 2, T_NONE, 0, 0, 0, 0, 0, 0, "R10 first load");
    issue(OP_AMOV, T_TEMP, 1, T_IN, 2, 0, 0, 0, 0, 0, "R10 second load");
    issue(OP_JMP_C, T_IN, 2, T_NONE, 0, 0, 0, 2, W5, W6, "R10 branch completes two");
    flush();
    issue(OP_AMOV, T_IN, 5, T_NONE, 0, 0, 0, 0, 0, 0, "R10 first load");
    issue(OP_AMOV, T_IN, 5, T_NONE, 0, 0, 0, 0, 0, 0, "R10 second load");
    issue(OP_END, T_IN, 5, T_NONE, 0, 0, 0, 2, W3, W6, "R10 end completes two");
  endtask

  task automatic t_gap();
    flush();
    issue(OP_AMOV, T_TEMP, 0, T_NONE, 0, 0, 0, 0, 0, 0, "R11 load");
    issue(OP_NOP, T_NONE, 0, T_NONE, 0, 0, 0, 0, 0, 0, "R11 nop");
    issue(OP_END, T_NONE, 0, T_NONE, 0, 0, 0, 0, 0, 0, "R11 end after gap");
    issue(OP_AMOV, T_TEMP, 0, T_NONE, 0, 0, 0, 0, 0, 0, "R11 load");
    issue(OP_NOP, T_NONE, 0, T_NONE, 0, 0, 0, 0, 0, 0, "R11 nop");
    issue(OP_CALL, T_NONE, 0, T_NONE, 0, 0, 0, 0, 0, 0, "R11 branch after gap");
  endtask

  task automatic t_reset_mid();
    issue(OP_AMOV, T_TEMP, 0, T_NONE, 0, 0, 0, 0, 0, 0, "R1 load before reset");
    do_reset();
    issue(OP_END, T_NONE, 0, T_NONE, 0, 0, 0, 0, 0, 0, "R1 end after reset");
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    t_reset();
    t_amov_end();
    t_out_end();
    t_addr_use();
    t_branch();
    t_input_pair();
    t_same_reg();
    t_multi();
    t_gap();
    t_reset_mid();
    done = 1;
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete actual=hung expected=done");
      finish_run();
    end
  end

endmodule